// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is the target side of a two-wire serial memory. It holds 512 bytes as two 256-byte blocks. SCL and SDA come in as oversampled levels on the system clock. The block finds START and STOP conditions itself and checks each select byte against a fixed type code and two strap inputs. It answers by pulling SDA low through an output enable, and it never drives the line high.

Writes go into an 8-byte row buffer and reach the array only on a valid STOP. A self-timed programming interval follows. While it runs, select bytes get no acknowledge, so a master can poll for completion. Reads run from a pointer that survives between transfers. The master can set that pointer with an address-only write followed by a repeated START. During a read it steps through the whole 9-bit space and wraps.

Top module: `i2c_eep_target`

## Requirements
- R1: After reset, `sda_oe_o` is 0 and `busy_o` is 0.
- R2: A select byte is acknowledged in the 9th clock only if bits [7:4] equal 1010, bits [3:2] equal `strap_i[1:0]`, and the block is not busy. Any other select byte is not acknowledged, and the transfer is ignored until the next START.
- R3: A write select, then an address byte, then one data byte, then STOP stores the byte at {select bit 1, address}. A later read returns it.
- R4: During a write, after each data byte the low 3 address bits advance modulo 8 and the upper 6 stay fixed. A 9th or later byte overwrites an earlier one in the same row.
- R5: A write reaches the array only on a STOP that follows at least one complete data byte. A START before that STOP discards the buffered bytes, and a STOP after the address byte alone starts no programming.
- R6: A committing STOP raises `busy_o` for WRITE_CYCLES clocks. During that time select bytes are not acknowledged.
- R7: Random read is a write select, then an address byte, then a repeated START, then a read select. If the read select's upper 7 bits differ from the write select's upper 7 bits, it is not acknowledged.
- R8: A read select with no preceding address byte starts at {select bit 1, low 8 bits of the pointer}. The pointer is left at the address after the last byte read or written.
- R9: In a read, each master acknowledge makes the next byte come from the pointer plus 1, and 0x1FF is followed by 0x000.
- R10: A read ends when the master does not acknowledge a data byte. The block then releases SDA and ignores further clocks until the next START.
- R11: Select bit 1 picks the block, so offset N in block 0 and offset N in block 1 hold separate bytes.
- R12: `sda_oe_o` changes only while SCL is low. A START at any point, even mid-byte, begins a new select byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level as seen on the wire |
| strap_i | input | 2 | Address strap inputs matched against select bits [3:2] |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | High while the programming interval runs |

## Verification
A wrong internal state shows up on the wire within one byte. A bad pointer returns a wrong data byte on the next read. A bad row or lane index in the write buffer becomes visible only after the programming interval, when a readback returns a byte at the wrong place. A stuck busy timer, or a select decoder that ignores the straps, changes the acknowledge bit of the very next select. A bit-counter error shifts the acknowledge slot and corrupts every byte after it.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEVSEL, ST_ACK_DEV, ST_ADDR, ST_ACK_ADDR,
    ST_WDATA, ST_ACK_WR, ST_RDATA, ST_ACK_RD
  } eep_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES:0] scl_q, sda_q;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[STAGES-1:0], scl_i};
      sda_q <= {sda_q[STAGES-1:0], sda_i};
    end
  end

  assign scl_o = scl_q[STAGES-1];
  assign sda_o = sda_q[STAGES-1];
  assign scl_p = scl_q[STAGES];
  assign sda_p = sda_q[STAGES];

  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_W = 3,
  parameter int DATA_W = 8,
  localparam int PAGES = 1 << PAGE_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clr_i,
  input  logic                           wr_i,
  input  logic [PAGE_W-1:0]              idx_i,
  input  logic [DATA_W-1:0]              data_i,
  output logic [PAGES-1:0][DATA_W-1:0]   buf_o,
  output logic [PAGES-1:0]               mask_o
);
  for (genvar g = 0; g < PAGES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        buf_o[g]  <= '0;
        mask_o[g] <= 1'b0;
      end else if (clr_i) begin
        mask_o[g] <= 1'b0;
      end else if (wr_i && idx_i == PAGE_W'(g)) begin
        buf_o[g]  <= data_i;
        mask_o[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 3,
  parameter int DATA_W = 8,
  localparam int PAGES = 1 << PAGE_W,
  localparam int ROW_W = ADDR_W - PAGE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                         clk_i,
  input  logic                         commit_i,
  input  logic [ROW_W-1:0]             row_i,
  input  logic [PAGES-1:0][DATA_W-1:0] buf_i,
  input  logic [PAGES-1:0]             mask_i,
  input  logic [ADDR_W-1:0]            rd_addr_i,
  output logic [DATA_W-1:0]            rd_data_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < PAGES; i++) begin
      if (commit_i && mask_i[i]) mem[{row_i, PAGE_W'(i)}] <= buf_i[i];
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
  parameter int CYCLES = 1_000_000,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/i2c_eep_target.sv
module i2c_eep_target #(
  parameter int STRAP_W      = 2,
  parameter int PAGE_W       = 3,
  parameter int WRITE_CYCLES = 1_000_000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_oe_o,
  output logic               busy_o
);
  import eep_pkg::*;

  localparam int BLK_W  = 8 - 4 - STRAP_W - 1;
  localparam int ADDR_W = 8 + BLK_W;
  localparam int PAGES  = 1 << PAGE_W;
  localparam int ROW_W  = ADDR_W - PAGE_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  eep_state_e st;
  logic [3:0] cnt;
  logic [7:0] rx_sr, tx_sr;
  logic [ADDR_W-1:0] ptr;
  logic [6:0] sel_hi;
  logic sel_rw, rnd_ok, wr_pend, oe_q, mack;
  logic [7:0] rd_data;
  logic [PAGES-1:0][7:0] pb_data;
  logic [PAGES-1:0] pb_mask;
  logic byte_end, dev_hit, pb_wr, commit;

  eep_sync u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  assign byte_end = scl_fall && (cnt == 4'd8);
  assign dev_hit  = (rx_sr[7:4] == DEV_TYPE) &&
                    (rx_sr[BLK_W+STRAP_W:BLK_W+1] == strap_i) && !busy_o;
  assign pb_wr    = !start_det && !stop_det && (st == ST_WDATA) && byte_end;
  assign commit   = stop_det && wr_pend && !busy_o;

  eep_page_buf #(.PAGE_W(PAGE_W), .DATA_W(8)) u_pbuf (
    .clk_i, .rst_ni, .clr_i(start_det | stop_det), .wr_i(pb_wr),
    .idx_i(ptr[PAGE_W-1:0]), .data_i(rx_sr), .buf_o(pb_data), .mask_o(pb_mask)
  );

  eep_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(8)) u_array (
    .clk_i, .commit_i(commit), .row_i(ptr[ADDR_W-1:PAGE_W]),
    .buf_i(pb_data), .mask_i(pb_mask), .rd_addr_i(ptr), .rd_data_o(rd_data)
  );

  eep_prog_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(commit), .busy_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; cnt <= '0; rx_sr <= '0; tx_sr <= '0; ptr <= '0;
      sel_hi <= '0; sel_rw <= 1'b0; rnd_ok <= 1'b0; wr_pend <= 1'b0;
      oe_q <= 1'b0; mack <= 1'b0;
    end else if (start_det) begin
      st <= ST_DEVSEL; cnt <= '0; oe_q <= 1'b0; wr_pend <= 1'b0;
    end else if (stop_det) begin
      st <= ST_IDLE; oe_q <= 1'b0; wr_pend <= 1'b0; rnd_ok <= 1'b0;
    end else begin
      unique case (st)
        ST_DEVSEL, ST_ADDR, ST_WDATA: begin
          if (scl_rise) begin
            rx_sr <= {rx_sr[6:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (byte_end) begin
            cnt <= '0;
            if (st == ST_DEVSEL) begin
              if (!dev_hit) begin
                st <= ST_IDLE;
              end else if (!rx_sr[0]) begin
                sel_hi <= rx_sr[7:1]; sel_rw <= 1'b0; rnd_ok <= 1'b0;
                oe_q <= 1'b1; st <= ST_ACK_DEV;
              end else if (!rnd_ok || rx_sr[7:1] == sel_hi) begin
                ptr[ADDR_W-1:8] <= rx_sr[BLK_W:1];
                sel_rw <= 1'b1; rnd_ok <= 1'b0;
                oe_q <= 1'b1; st <= ST_ACK_DEV;
              end else begin
                st <= ST_IDLE;  // R7: select mismatch in random read
              end
            end else if (st == ST_ADDR) begin
              ptr <= {sel_hi[BLK_W-1:0], rx_sr};
              rnd_ok <= 1'b1; oe_q <= 1'b1; st <= ST_ACK_ADDR;
            end else begin
              ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;  // wraps inside the row
              wr_pend <= 1'b1; rnd_ok <= 1'b0; oe_q <= 1'b1; st <= ST_ACK_WR;
            end
          end
        end
        ST_ACK_DEV: if (scl_fall) begin
          if (sel_rw) begin
            tx_sr <= rd_data; oe_q <= ~rd_data[7]; cnt <= '0; st <= ST_RDATA;
          end else begin
            oe_q <= 1'b0; st <= ST_ADDR;
          end
        end
        ST_ACK_ADDR, ST_ACK_WR: if (scl_fall) begin
          oe_q <= 1'b0; st <= ST_WDATA;
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              oe_q <= 1'b0; ptr <= ptr + 1'b1; st <= ST_ACK_RD;
            end else begin
              tx_sr <= {tx_sr[6:0], 1'b0}; oe_q <= ~tx_sr[6];
            end
          end
        end
        ST_ACK_RD: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              tx_sr <= rd_data; oe_q <= ~rd_data[7]; cnt <= '0; st <= ST_RDATA;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/eep_chk.sv
module eep_chk
  import eep_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s_i,
  input logic              start_i,
  input logic              stop_i,
  input logic              sda_oe_i,
  input logic              busy_i,
  input eep_state_e        st_i,
  input logic [ADDR_W-1:0] ptr_i
);
  // R12
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> !$past(scl_s_i));

  // R12
  start_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (st_i == ST_DEVSEL) && !sda_oe_i);

  // R5
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (st_i == ST_IDLE) && !sda_oe_i);

  // R6
  busy_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> st_i != ST_ACK_DEV);

  // R6
  busy_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(stop_i));

  // R4
  row_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_ACK_WR && $past(st_i) == ST_WDATA) |->
      ptr_i[ADDR_W-1:PAGE_W] == $past(ptr_i[ADDR_W-1:PAGE_W]));
endmodule

bind i2c_eep_target eep_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .start_i(start_det),
  .stop_i(stop_det), .sda_oe_i(sda_oe_o), .busy_i(busy_o), .st_i(st), .ptr_i(ptr)
);

// File: tb/tb_i2c_eep_target.sv
module tb_i2c_eep_target;
  localparam int WC = 2000;
  localparam int Q  = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sda_oe, busy;
  wire  sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_eep_target #(.WRITE_CYCLES(WC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(strap), .sda_oe_o(sda_oe), .busy_o(busy)
  );

  int n_chk = 0, n_fail = 0;
  string      exp_req[$];
  logic [7:0] exp_val[$];

  task automatic push_exp(string r, logic [7:0] v);
    exp_req.push_back(r); exp_val.push_back(v);
  endtask

  task automatic mon_cmp(logic [7:0] act);
    string r; logic [7:0] e;
    r = exp_req.pop_front(); e = exp_val.pop_front();
    n_chk++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", r, act, e);
    end
  endtask

  task automatic chk(string r, logic [7:0] act, logic [7:0] e);
    push_exp(r, e); mon_cmp(act);
  endtask

  task automatic tick; repeat (Q) @(negedge clk); endtask

  task automatic i2c_start;
    sda_m = 1'b1; tick; scl_m = 1'b1; tick; sda_m = 1'b0; tick; scl_m = 1'b0; tick;
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; tick; scl_m = 1'b1; tick; sda_m = 1'b1; tick; tick;
  endtask

  task automatic put_bit(logic b);
    sda_m = b; tick; scl_m = 1'b1; tick; tick; scl_m = 1'b0; tick;
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick; scl_m = 1'b1; tick; b = sda_line; tick; scl_m = 1'b0; tick;
  endtask

  task automatic wr_byte(string r, logic [7:0] v, logic exp_ack);
    logic b;
    push_exp(r, {7'd0, exp_ack});
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    mon_cmp({7'd0, ~b});
  endtask

  task automatic rd_byte(string r, logic [7:0] e, logic last);
    logic [7:0] d; logic b;
    push_exp(r, e);
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    mon_cmp(d);
    put_bit(last);
  endtask

  function automatic logic [7:0] sel(logic blk, logic rw);
    return {4'b1010, strap, blk, rw};
  endfunction

  task automatic wait_prog;
    repeat (WC + 50) @(negedge clk);
    chk("R6", {7'd0, busy}, 8'h00);
  endtask

  task automatic byte_write(string r, logic [8:0] a, logic [7:0] v);
    i2c_start; wr_byte(r, sel(a[8], 1'b0), 1'b1); wr_byte(r, a[7:0], 1'b1);
    wr_byte(r, v, 1'b1); i2c_stop;
    chk("R6", {7'd0, busy}, 8'h01);
    wait_prog;
  endtask

  task automatic set_ptr_read(string r, logic [8:0] a);
    i2c_start; wr_byte(r, sel(a[8], 1'b0), 1'b1); wr_byte(r, a[7:0], 1'b1);
    i2c_start; wr_byte(r, sel(a[8], 1'b1), 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {6'd0, sda_oe, busy}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {6'd0, sda_oe, busy}, 8'h00);

    // R2: wrong type code, then a further byte is still ignored
    i2c_start; wr_byte("R2", 8'b1001_1000, 1'b0); wr_byte("R2", 8'h00, 1'b0); i2c_stop;
    // R2: strap mismatch
    i2c_start; wr_byte("R2", {4'b1010, 2'b01, 2'b00}, 1'b0); i2c_stop;

    // R3: byte write, busy polling (R6)
    i2c_start; wr_byte("R3", sel(1'b0, 1'b0), 1'b1); wr_byte("R3", 8'h10, 1'b1);
    wr_byte("R3", 8'hA5, 1'b1); i2c_stop;
    chk("R6", {7'd0, busy}, 8'h01);
    i2c_start; wr_byte("R6", sel(1'b0, 1'b0), 1'b0); i2c_stop;
    wait_prog;
    set_ptr_read("R3", 9'h010); rd_byte("R3", 8'hA5, 1'b1); i2c_stop;

    // R5: data followed by repeated START is discarded
    i2c_start; wr_byte("R5", sel(1'b0, 1'b0), 1'b1); wr_byte("R5", 8'h10, 1'b1);
    wr_byte("R5", 8'h77, 1'b1); i2c_start; i2c_stop;
    chk("R5", {7'd0, busy}, 8'h00);
    // R5: address only then STOP starts no programming
    i2c_start; wr_byte("R5", sel(1'b0, 1'b0), 1'b1); wr_byte("R5", 8'h10, 1'b1); i2c_stop;
    chk("R5", {7'd0, busy}, 8'h00);
    set_ptr_read("R5", 9'h010); rd_byte("R5", 8'hA5, 1'b1); i2c_stop;

    // R4: ten bytes into block 1 from 0x3D, wrapping in the row
    i2c_start; wr_byte("R4", sel(1'b1, 1'b0), 1'b1); wr_byte("R4", 8'h3D, 1'b1);
    for (int i = 0; i < 10; i++) wr_byte("R4", 8'hC0 + 8'(i), 1'b1);
    i2c_stop;
    chk("R6", {7'd0, busy}, 8'h01);
    wait_prog;
    set_ptr_read("R4", 9'h138);
    for (int i = 0; i < 7; i++) rd_byte("R4", 8'hC3 + 8'(i), (i == 6));
    i2c_stop;
    // R8: current-address read continues at 0x13F
    i2c_start; wr_byte("R8", sel(1'b1, 1'b1), 1'b1); rd_byte("R8", 8'hC2, 1'b1); i2c_stop;

    // R11: same offset in block 0
    byte_write("R11", 9'h03D, 8'h5A);
    set_ptr_read("R11", 9'h13D); rd_byte("R11", 8'hC8, 1'b1); i2c_stop;
    set_ptr_read("R11", 9'h03D); rd_byte("R11", 8'h5A, 1'b1); i2c_stop;
    // R8: pointer now 0x03E, block bit taken from the read select
    i2c_start; wr_byte("R8", sel(1'b1, 1'b1), 1'b1); rd_byte("R8", 8'hC9, 1'b1); i2c_stop;

    // R9: wrap from 0x1FF to 0x000
    i2c_start; wr_byte("R9", sel(1'b1, 1'b0), 1'b1); wr_byte("R9", 8'hFE, 1'b1);
    wr_byte("R9", 8'hE1, 1'b1); wr_byte("R9", 8'hE2, 1'b1); i2c_stop;
    wait_prog;
    byte_write("R9", 9'h000, 8'h0B);
    set_ptr_read("R9", 9'h1FE);
    rd_byte("R9", 8'hE1, 1'b0); rd_byte("R9", 8'hE2, 1'b0); rd_byte("R10", 8'h0B, 1'b1);
    // R10: after NACK the block leaves SDA released
    rd_byte("R10", 8'hFF, 1'b1);
    i2c_stop;

    // R7: read select with a different block bit is refused
    i2c_start; wr_byte("R7", sel(1'b0, 1'b0), 1'b1); wr_byte("R7", 8'h10, 1'b1);
    i2c_start; wr_byte("R7", sel(1'b1, 1'b1), 1'b0); i2c_stop;

    // R12: START in the middle of a byte restarts select decoding
    i2c_start; put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    i2c_start; wr_byte("R12", sel(1'b0, 1'b1), 1'b1); rd_byte("R12", 8'hA5, 1'b1);
    i2c_stop;

    repeat (20) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule